// File: doc/BRIEF.md
# Dual 8-bit Compare-Match Timer

This block contains two 8-bit up-counters on a small register bus that takes byte and halfword accesses. Each channel has two compare registers, a clock-control byte that picks a prescaled tap of the input clock, and a control byte. The control byte can restart the counter on either compare and can enable three single-cycle interrupt pulses: compare A, compare B and overflow. One 13-bit divider runs freely and is shared by both channels. A channel counts on every cycle in which its selected tap fires.

Channel 1 can also be chained to channel 0, so that it advances once on each compare-A match of channel 0. Alternatively, channel 0 can fuse both channels into one 16-bit counter. In that mode channel 0 holds the high byte and channel 1 the low byte. The 16-bit counter runs at channel 0's prescale and uses the concatenated compare values. Only channel 0's control byte and interrupt outputs are active.

The status byte and the top bit of the clock-control byte have no effect on counting. They are stored and read back only.

Top module: `cm_timer_pair`

## Requirements
- R1: Register decode and reset values.
  - `bus_addr[0]` selects the channel. `bus_addr[3:1]` selects the register: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 clock control.
  - A byte read returns the value in bits 7:0, with bits 15:8 zero.
  - After reset: counters read 0x00, compares 0xFF, control and clock control 0x00. Status reads 0x00 on channel 0 and 0x10 on channel 1.
- R2: Read-back masks.
  - Control bits 2:0 read 0.
  - Clock-control bits 6:5 read 0.
  - Status bits 7:6 read 0.
  - Channel 1 status bits 5:4 always read 01.
- R3: Clock control bits 4:3 select the source; the value 1 counts internal ticks. Bits 2:0 select the rate:
  - 0: stopped
  - 1: divide by 1
  - 2: divide by 2
  - 3: divide by 8
  - 4: divide by 32
  - 5: divide by 64
  - 6: divide by 1024
  - 7: divide by 8192

  Over any 64 consecutive cycles at divide-by-8, a running counter advances exactly 8 times. With rate 0 it holds its value.
- R4: Compare clear. On a count edge where the counter equals a compare value, that compare matches. If control bits 4:3 select that compare, the counter becomes 0 instead of incrementing: the value 1 selects compare A, the value 2 selects compare B.
- R5: Interrupt enables. Control bit 6 enables the compare-A pulse, bit 7 the compare-B pulse and bit 5 the overflow pulse. Each pulse lasts one cycle and is high in the cycle after its count edge. A disabled event gives no pulse.
- R6: Overflow. A count edge at 0xFF wraps the counter to 0x00 and raises the overflow event.
- R7: Fused mode. Channel 0 clock-control source value 3 fuses the counters into {channel 0, channel 1}.
  - The fused counter counts at channel 0's rate and compares against {compare0, compare1}.
  - It clears per channel 0's control byte and overflows when it passes 0xFFFF.
  - Only channel 0's interrupt outputs pulse; channel 1's stay low.
- R8: Chained mode. When channel 1's source is 3 and the channels are not fused, channel 1 increments once per channel 0 compare-A match.
- R9: Halfword access. With `bus_half` high at even addresses of compare A, compare B, counter and clock control, bits 15:8 belong to channel 0 and bits 7:0 to channel 1. Some accesses are rejected: a write is ignored and a read returns 0xFFFF. Rejected accesses are:
  - any halfword access to an odd address, the control register or the status register;
  - any access to register codes 6 and 7.
- R10: A bus write to a counter byte wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte |
| bus_addr | input | 4 | Byte address; bit 0 = channel |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq_cmpa | output | 2 | Compare-A pulse per channel |
| irq_cmpb | output | 2 | Compare-B pulse per channel |
| irq_ovf | output | 2 | Overflow pulse per channel |

## Verification
The in-module assertions check several rules on every cycle:
- A stopped channel 0 holds its count unless written.
- The counter reads zero just after an overflow pulse, and just after a compare-A pulse that clears it.
- Channel 1's pulses stay silent while the channels are fused.
- A rejected halfword write leaves the compare and clock registers untouched.

Only the directed scenarios can show the rest: exact increment counts per prescale rate, clear periods, the chained advance, fused 16-bit wrap, halfword byte lanes and read masks, and write-over-increment priority.

// File: rtl/cm_timer_pair.sv
module cm_timer_pair #(
  parameter int DIV_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_half,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [1:0]  irq_cmpa,
  output logic [1:0]  irq_cmpb,
  output logic [1:0]  irq_ovf
);
  localparam logic [2:0] RG_CTL = 3'd0, RG_STAT = 3'd1, RG_CMPA = 3'd2,
                         RG_CMPB = 3'd3, RG_CNT = 3'd4, RG_CKC = 3'd5;
  localparam logic [1:0] SRC_INT = 2'd1, SRC_LINK = 2'd3;
  localparam logic [1:0] CLR_A = 2'd1, CLR_B = 2'd2;

  logic [7:0] ctl [2];
  logic [7:0] stat [2];
  logic [7:0] cmpa [2];
  logic [7:0] cmpb [2];
  logic [7:0] cnt [2];
  logic [7:0] ckc [2];
  logic [DIV_W-1:0] div;

  // bus decode
  logic [2:0] rsel;
  logic       bch, bad_acc, wr_go;
  logic [1:0] we_ch, cnt_we;
  logic [7:0] wd [2];

  assign rsel    = bus_addr[3:1];
  assign bch     = bus_addr[0];
  assign bad_acc = (rsel > RG_CKC) ||
                   (bus_half && (bch || rsel == RG_CTL || rsel == RG_STAT));
  assign wr_go   = bus_sel && bus_wr && !bad_acc;
  assign we_ch[0] = wr_go && (bus_half || !bch);
  assign we_ch[1] = wr_go && (bus_half || bch);
  assign wd[0]   = bus_half ? bus_wdata[15:8] : bus_wdata[7:0];
  assign wd[1]   = bus_wdata[7:0];
  assign cnt_we  = (rsel == RG_CNT) ? we_ch : 2'b00;

  // prescaler taps
  function automatic logic tap(input logic [2:0] cks, input logic [DIV_W-1:0] d);
    case (cks)
      3'd1:    tap = 1'b1;
      3'd2:    tap = d[0];
      3'd3:    tap = &d[2:0];
      3'd4:    tap = &d[4:0];
      3'd5:    tap = &d[5:0];
      3'd6:    tap = &d[9:0];
      3'd7:    tap = &d[12:0];
      default: tap = 1'b0;
    endcase
  endfunction

  logic fused, tick0, tick1;
  assign fused = ckc[0][4:3] == SRC_LINK;
  assign tick0 = tap(ckc[0][2:0], div);
  assign tick1 = tap(ckc[1][2:0], div);

  // separate mode, channel 0
  logic step0, hit_a0, hit_b0, wrap0, clr0;
  assign step0  = !fused && ckc[0][4:3] == SRC_INT && tick0;
  assign hit_a0 = step0 && cnt[0] == cmpa[0];
  assign hit_b0 = step0 && cnt[0] == cmpb[0];
  assign wrap0  = step0 && cnt[0] == 8'hFF;
  assign clr0   = (hit_a0 && ctl[0][4:3] == CLR_A) || (hit_b0 && ctl[0][4:3] == CLR_B);

  // separate mode, channel 1 (internal or chained to channel 0 compare A)
  logic step1, hit_a1, hit_b1, wrap1, clr1;
  assign step1  = !fused && ((ckc[1][4:3] == SRC_INT && tick1) ||
                             (ckc[1][4:3] == SRC_LINK && hit_a0));
  assign hit_a1 = step1 && cnt[1] == cmpa[1];
  assign hit_b1 = step1 && cnt[1] == cmpb[1];
  assign wrap1  = step1 && cnt[1] == 8'hFF;
  assign clr1   = (hit_a1 && ctl[1][4:3] == CLR_A) || (hit_b1 && ctl[1][4:3] == CLR_B);

  // fused 16-bit mode
  logic        fstep, f_a, f_b, f_wrap, f_clr;
  logic [15:0] c16, n16;
  assign c16    = {cnt[0], cnt[1]};
  assign fstep  = fused && tick0;
  assign f_a    = fstep && c16 == {cmpa[0], cmpa[1]};
  assign f_b    = fstep && c16 == {cmpb[0], cmpb[1]};
  assign f_wrap = fstep && c16 == 16'hFFFF;
  assign f_clr  = (f_a && ctl[0][4:3] == CLR_A) || (f_b && ctl[0][4:3] == CLR_B);
  assign n16    = f_clr ? 16'h0000 : c16 + 16'h0001;

  logic [7:0] cnt_nx [2];
  always_comb begin
    if (fstep) begin
      cnt_nx[0] = n16[15:8];
      cnt_nx[1] = n16[7:0];
    end else begin
      cnt_nx[0] = step0 ? (clr0 ? 8'h00 : cnt[0] + 8'h01) : cnt[0];
      cnt_nx[1] = step1 ? (clr1 ? 8'h00 : cnt[1] + 8'h01) : cnt[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div      <= '0;
      irq_cmpa <= '0;
      irq_cmpb <= '0;
      irq_ovf  <= '0;
      for (int c = 0; c < 2; c++) begin
        ctl[c]  <= 8'h00;
        stat[c] <= (c == 1) ? 8'h10 : 8'h00;
        cmpa[c] <= 8'hFF;
        cmpb[c] <= 8'hFF;
        cnt[c]  <= 8'h00;
        ckc[c]  <= 8'h00;
      end
    end else begin
      div <= div + 1'b1;
      irq_cmpa[0] <= (fused ? f_a    : hit_a0) && ctl[0][6];
      irq_cmpb[0] <= (fused ? f_b    : hit_b0) && ctl[0][7];
      irq_ovf[0]  <= (fused ? f_wrap : wrap0)  && ctl[0][5];
      irq_cmpa[1] <= hit_a1 && ctl[1][6];
      irq_cmpb[1] <= hit_b1 && ctl[1][7];
      irq_ovf[1]  <= wrap1  && ctl[1][5];
      for (int c = 0; c < 2; c++) begin
        cnt[c] <= cnt_we[c] ? wd[c] : cnt_nx[c];
        if (we_ch[c]) begin
          case (rsel)
            RG_CTL:  ctl[c]  <= wd[c] & 8'hF8;
            RG_STAT: stat[c] <= wd[c] & 8'h3F;
            RG_CMPA: cmpa[c] <= wd[c];
            RG_CMPB: cmpb[c] <= wd[c];
            RG_CKC:  ckc[c]  <= wd[c] & 8'h9F;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [7:0] rd_byte(input logic [2:0] r, input logic c);
    case (r)
      RG_CTL:  rd_byte = ctl[c];
      RG_STAT: rd_byte = c ? {4'b0001, stat[1][3:0]} : stat[0];
      RG_CMPA: rd_byte = cmpa[c];
      RG_CMPB: rd_byte = cmpb[c];
      RG_CNT:  rd_byte = cnt[c];
      RG_CKC:  rd_byte = ckc[c];
      default: rd_byte = 8'hFF;
    endcase
  endfunction

  assign bus_rdata = bad_acc  ? 16'hFFFF :
                     bus_half ? {rd_byte(rsel, 1'b0), rd_byte(rsel, 1'b1)} :
                                {8'h00, rd_byte(rsel, bch)};

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckc[0] == 8'h00 && !cnt_we[0]) |=> $stable(cnt[0]));

  // R6
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf[0] && !$past(cnt_we[0])) |-> cnt[0] == 8'h00);

  // R4
  clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmpa[0] && $past(ctl[0][4:3] == CLR_A) && !$past(cnt_we[0])) |-> cnt[0] == 8'h00);

  // R7
  fused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fused) |-> (irq_cmpa[1] == 1'b0 && irq_cmpb[1] == 1'b0 && irq_ovf[1] == 1'b0));

  // R9
  reject_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_half && bus_addr[0]) |=>
      ($stable(cmpa[0]) && $stable(cmpa[1]) && $stable(cmpb[0]) &&
       $stable(cmpb[1]) && $stable(ckc[0]) && $stable(ckc[1])));
endmodule

// File: tb/cm_timer_pair_tb.sv
module cm_timer_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_cmpa, irq_cmpb, irq_ovf;

  int errs = 0, total = 0;
  int pa0 = 0, pa1 = 0, pb0 = 0, pb1 = 0, po0 = 0, po1 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cm_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb),
    .irq_ovf(irq_ovf));

  always @(negedge clk) begin
    if (irq_cmpa[0]) pa0++;
    if (irq_cmpa[1]) pa1++;
    if (irq_cmpb[0]) pb0++;
    if (irq_cmpb[1]) pb1++;
    if (irq_ovf[0])  po0++;
    if (irq_ovf[1])  po1++;
  end

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic h, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_half = h; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_half = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, input logic h, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_half = h; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0; bus_half = 1'b0;
  endtask

  // channel 0 runs for exactly k clock edges (k >= 2)
  task automatic run_for(input logic [7:0] ckcv, input int k);
    bw(4'd10, 1'b0, {8'h00, ckcv});
    repeat (k - 2) @(negedge clk);
    bw(4'd10, 1'b0, 16'h0000);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int c = 0; c < 2; c++) begin
      br(4'd8 + 4'(c), 1'b0, v);  chk("R1 counter reset", v, 16'h0000);
      br(4'd4 + 4'(c), 1'b0, v);  chk("R1 compare A reset", v, 16'h00FF);
      br(4'd6 + 4'(c), 1'b0, v);  chk("R1 compare B reset", v, 16'h00FF);
      br(4'd0 + 4'(c), 1'b0, v);  chk("R1 control reset", v, 16'h0000);
      br(4'd10 + 4'(c), 1'b0, v); chk("R1 clock control reset", v, 16'h0000);
    end
    br(4'd2, 1'b0, v); chk("R1 status ch0 reset", v, 16'h0000);
    br(4'd3, 1'b0, v); chk("R1 status ch1 reset", v, 16'h0010);
  endtask

  task automatic t_masks;
    logic [15:0] v;
    bw(4'd0, 1'b0, 16'h00FF);  br(4'd0, 1'b0, v);  chk("R2 control mask", v, 16'h00F8);
    bw(4'd0, 1'b0, 16'h0000);
    bw(4'd11, 1'b0, 16'h00E0); br(4'd11, 1'b0, v); chk("R2 clock control mask", v, 16'h0080);
    bw(4'd11, 1'b0, 16'h0000);
    bw(4'd3, 1'b0, 16'h00FF);  br(4'd3, 1'b0, v);  chk("R2 status ch1 forced bits", v, 16'h001F);
    bw(4'd2, 1'b0, 16'h00FF);  br(4'd2, 1'b0, v);  chk("R2 status ch0 mask", v, 16'h003F);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    bw(4'd8, 1'b0, 16'h0000); run_for(8'h09, 10);
    br(4'd8, 1'b0, v); chk("R3 divide-by-1 count", v, 16'h000A);
    bw(4'd8, 1'b0, 16'h0000); run_for(8'h0A, 64);
    br(4'd8, 1'b0, v); chk("R3 divide-by-2 count", v, 16'h0020);
    bw(4'd8, 1'b0, 16'h0000); run_for(8'h0B, 64);
    br(4'd8, 1'b0, v); chk("R3 divide-by-8 count", v, 16'h0008);
    bw(4'd8, 1'b0, 16'h0000); run_for(8'h08, 20);
    br(4'd8, 1'b0, v); chk("R3 rate 0 stopped", v, 16'h0000);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    int o0, a0;
    bw(4'd0, 1'b0, 16'h0020); bw(4'd8, 1'b0, 16'h00FC);
    o0 = po0; a0 = pa0;
    run_for(8'h09, 6);
    br(4'd8, 1'b0, v); chk("R6 wrap past 0xFF", v, 16'h0002);
    chk("R6 overflow pulse count", 16'(po0 - o0), 16'd1);
    chk("R5 disabled compare A silent", 16'(pa0 - a0), 16'd0);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    int a0, b0;
    bw(4'd4, 1'b0, 16'h0004); bw(4'd0, 1'b0, 16'h0048); bw(4'd8, 1'b0, 16'h0000);
    a0 = pa0;
    run_for(8'h09, 12);
    br(4'd8, 1'b0, v); chk("R4 clear on compare A", v, 16'h0002);
    chk("R5 compare A pulses", 16'(pa0 - a0), 16'd2);
    bw(4'd6, 1'b0, 16'h0002); bw(4'd0, 1'b0, 16'h0090); bw(4'd8, 1'b0, 16'h0000);
    a0 = pa0; b0 = pb0;
    run_for(8'h09, 7);
    br(4'd8, 1'b0, v); chk("R4 clear on compare B", v, 16'h0001);
    chk("R5 compare B pulses", 16'(pb0 - b0), 16'd2);
    chk("R5 compare A disabled", 16'(pa0 - a0), 16'd0);
  endtask

  task automatic t_chain;
    logic [15:0] v;
    bw(4'd4, 1'b0, 16'h0003); bw(4'd0, 1'b0, 16'h0008);
    bw(4'd8, 1'b0, 16'h0000); bw(4'd9, 1'b0, 16'h0000);
    bw(4'd11, 1'b0, 16'h0018);
    run_for(8'h09, 12);
    br(4'd9, 1'b0, v); chk("R8 chained channel 1 count", v, 16'h0003);
    br(4'd8, 1'b0, v); chk("R8 channel 0 after clears", v, 16'h0000);
    bw(4'd11, 1'b0, 16'h0000); bw(4'd0, 1'b0, 16'h0000);
  endtask

  task automatic t_fused;
    logic [15:0] v;
    int a0, a1, b1, o0, o1;
    bw(4'd4, 1'b1, 16'h0105); bw(4'd6, 1'b1, 16'hFFFF); bw(4'd8, 1'b1, 16'h00FE);
    bw(4'd0, 1'b0, 16'h0048); bw(4'd1, 1'b0, 16'h00E0);
    a0 = pa0; a1 = pa1; b1 = pb1; o1 = po1;
    run_for(8'h19, 10);
    br(4'd8, 1'b1, v); chk("R7 fused clear on 16-bit compare", v, 16'h0002);
    chk("R7 fused compare A pulse", 16'(pa0 - a0), 16'd1);
    chk("R7 channel 1 silent when fused", 16'((pa1 - a1) + (pb1 - b1) + (po1 - o1)), 16'd0);
    bw(4'd4, 1'b1, 16'hFFFF); bw(4'd0, 1'b0, 16'h0020); bw(4'd8, 1'b1, 16'hFFFD);
    o0 = po0; o1 = po1;
    run_for(8'h19, 5);
    br(4'd8, 1'b1, v); chk("R7 fused wrap past 0xFFFF", v, 16'h0002);
    chk("R7 fused overflow pulse", 16'(po0 - o0), 16'd1);
    chk("R7 channel 1 overflow silent", 16'(po1 - o1), 16'd0);
    bw(4'd1, 1'b0, 16'h0000);
  endtask

  task automatic t_half;
    logic [15:0] v;
    bw(4'd5, 1'b1, 16'h1234);
    br(4'd4, 1'b0, v); chk("R9 odd halfword write ignored ch0", v, 16'h00FF);
    br(4'd5, 1'b0, v); chk("R9 odd halfword write ignored ch1", v, 16'h00FF);
    br(4'd5, 1'b1, v); chk("R9 odd halfword read", v, 16'hFFFF);
    bw(4'd0, 1'b1, 16'hFFFF);
    br(4'd0, 1'b0, v); chk("R9 control halfword write ignored", v, 16'h0020);
    br(4'd2, 1'b1, v); chk("R9 status halfword read", v, 16'hFFFF);
    br(4'd12, 1'b0, v); chk("R9 unmapped read", v, 16'hFFFF);
    bw(4'd6, 1'b1, 16'hA55A);
    br(4'd6, 1'b0, v); chk("R9 halfword high lane to ch0", v, 16'h00A5);
    br(4'd7, 1'b0, v); chk("R9 halfword low lane to ch1", v, 16'h005A);
    br(4'd6, 1'b1, v); chk("R9 halfword compare read", v, 16'hA55A);
    bw(4'd10, 1'b1, 16'hE0E0);
    br(4'd10, 1'b1, v); chk("R9 halfword clock control read", v, 16'h8080);
    bw(4'd10, 1'b1, 16'h0000);
    bw(4'd0, 1'b0, 16'h0000);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    bw(4'd8, 1'b0, 16'h0000);
    bw(4'd10, 1'b0, 16'h0009);
    bw(4'd8, 1'b0, 16'h0040);
    bw(4'd10, 1'b0, 16'h0000);
    repeat (2) @(negedge clk);
    br(4'd8, 1'b0, v); chk("R10 write beats increment", v, 16'h0042);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_masks;
    t_prescale;
    t_overflow;
    t_clear;
    t_chain;
    t_fused;
    t_half;
    t_priority;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end
endmodule